// File: doc/BRIEF.md
# Asynchronous Byte-Wide ROM Read Controller

This block sits between a synchronous host and an asynchronous byte-wide read-only memory with a 17-bit address. The host offers an address with a valid/ready handshake. The controller holds that address on the memory pins and pulls both the enable and the output-gate strobes low. It keeps them low for a cycle count derived at elaboration from the clock period and the selected speed grade. In the last cycle of that window it captures the data byte, and it returns the byte to the host with a one-cycle valid pulse.

After each read the controller raises both strobes. It then waits a float-recovery gap, which covers the time the memory may keep driving its data pins, before it accepts the next request. Only one read is in flight at a time. The programming strobe stays inactive for the whole time.

The controller is a three-state machine. In `ST_IDLE` (standby) it is ready for a request. In `ST_ACCESS` the strobes are low and the wait timers run. In `ST_FLOAT` it waits out the bus float time. The transitions are:
- *accept* (`ST_IDLE` to `ST_ACCESS`) on `req_valid` while ready.
- *sample* (`ST_ACCESS` to `ST_FLOAT`) when the address, enable and output-gate wait timers have all expired.
- *recover* (`ST_FLOAT` to `ST_IDLE`) when the float timer expires.

Top module: `rom_rd_ctrl`

## Requirements
- R1: Reset state. While `rst_n` is low and in the first cycle after it, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Standby. Whenever `req_ready` is 1, both `mem_ce_n` and `mem_oe_n` are 1.
- R3: `mem_pgm_n` is 1 at all times, including during reads.
- R4: Accept. If `req_valid` and `req_ready` are both 1 at a rising edge, then from that edge:
  - `mem_addr` equals the offered `req_addr`;
  - `mem_ce_n` and `mem_oe_n` are both 0;
  - `req_ready` is 0.
- R5: Wait window. For each of the three paths, the count is ceil(t / clock period) + 1, where t is:
  - address access: 120, 150 or 200 ns for grade 0, 1 or 2;
  - enable access: 120, 150 or 200 ns for grade 0, 1 or 2;
  - output-gate access: 60 ns for grade 0 and 70 ns for the other grades.

  The strobes stay low for exactly the largest of the three counts, in clock cycles. With the defaults (10 ns clock, grade 0) this is 13 cycles.
- R6: In the cycle right after the strobes rise, `rsp_valid` is 1 for exactly one cycle. `rsp_data` holds the `mem_dq` value present in the last cycle that the strobes were low.
- R7: `mem_addr` does not change while `mem_ce_n` is 0.
- R8: After the strobes rise, `req_ready` stays 0 for exactly ceil(50 ns / clock period) cycles (5 with the defaults). It then becomes 1, and the strobes stay high throughout that gap.
- R9: A `req_valid` pulse that falls while `req_ready` is 0 has no effect. `mem_addr` keeps the address in service, and no further read starts once the controller returns to standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host offers a read |
| req_ready | output | 1 | Controller can take a read |
| req_addr | input | 17 | Byte address of the read |
| rsp_data | output | 8 | Byte returned to the host |
| rsp_valid | output | 1 | One-cycle strobe qualifying `rsp_data` |
| mem_addr | output | 17 | Address pins of the memory |
| mem_ce_n | output | 1 | Memory enable, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_pgm_n | output | 1 | Programming strobe, held inactive (high) |
| mem_dq | input | 8 | Data pins from the memory |

## Verification
Two events can fall in the same cycle: the float timer expiring (the *recover* transition) and a host request that has been waiting. The bench raises `req_valid` with a new address in the cycle `rsp_valid` is seen and holds it through the gap. The check is that `req_ready` stays low for exactly the float count. The new read must start on the first ready edge, with its address on the pins and the strobes low in the very next cycle. The memory model returns a poison byte until the strobes have been low for the full window, so a controller that samples one cycle early returns the wrong data.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } rd_state_e;

    // integer ceiling division, used for picosecond-to-cycle conversion
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] dq,
    output logic [DW-1:0] data,
    output logic          valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                data <= dq;
            end
        end
    end

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int AW            = 17,
    parameter int DW            = 8,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int GRADE         = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_pgm_n,
    input  logic [DW-1:0] mem_dq
);
    // speed-grade timing, picoseconds
    localparam int T_ADDR_PS = (GRADE == 0) ? 120000 : (GRADE == 1) ? 150000 : 200000;
    localparam int T_CE_PS   = T_ADDR_PS;
    localparam int T_OE_PS   = (GRADE == 0) ? 60000 : 70000;
    localparam int T_FLT_PS  = 50000;

    localparam int N_ADDR = cdiv(T_ADDR_PS, CLK_PERIOD_PS) + 1;
    localparam int N_CE   = cdiv(T_CE_PS,   CLK_PERIOD_PS) + 1;
    localparam int N_OE   = cdiv(T_OE_PS,   CLK_PERIOD_PS) + 1;
    localparam int N_FLT  = imax(cdiv(T_FLT_PS, CLK_PERIOD_PS), 1);
    localparam int N_MAX  = imax(imax(N_ADDR, N_CE), imax(N_OE, N_FLT));
    localparam int CW     = $clog2(N_MAX + 1);
    localparam int NPATH  = 3;
    localparam int WAIT_N [NPATH] = '{N_ADDR, N_CE, N_OE};

    rd_state_e     state_q, state_d;
    logic [AW-1:0] addr_q;
    logic          accept, sample, all_done, flt_done;
    logic [NPATH-1:0] path_done;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign all_done = &path_done;
    assign sample = (state_q == ST_ACCESS) && all_done;

    // one wait timer per access-time limit
    for (genvar g = 0; g < NPATH; g++) begin : g_path
        rom_rd_timer #(.CW(CW)) u_wait (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .load_val (CW'(WAIT_N[g] - 1)),
            .done     (path_done[g])
        );
    end

    rom_rd_timer #(.CW(CW)) u_float (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sample),
        .load_val (CW'(N_FLT - 1)),
        .done     (flt_done)
    );

    rom_rd_capture #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (sample),
        .dq      (mem_dq),
        .data    (rsp_data),
        .valid   (rsp_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_ACCESS;
            ST_ACCESS: if (all_done) state_d = ST_FLOAT;
            ST_FLOAT:  if (flt_done) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_FLOAT:  req_ready = 1'b0;
            default:   req_ready = 1'b0;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_pgm_n = 1'b1;

    AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_ce_n && !mem_oe_n && !req_ready && mem_addr == $past(req_addr))) else $error("accept"); // R4
    AST_READY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n)) else $error("standby"); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)) else $error("addr hold"); // R7
    AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> rsp_valid) else $error("valid late"); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("valid width"); // R6
    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !req_ready) else $error("float gap"); // R8

endmodule

// File: tb/rom_rd_ctrl_tb.sv
module rom_rd_ctrl_tb;
    localparam int EXP_N = (120000 + 9999) / 10000 + 1;  // R5 default: 13
    localparam int EXP_F = (50000 + 9999) / 10000;       // R8 default: 5
    localparam int NVEC  = 6;
    localparam logic [16:0] VEC [NVEC] = '{17'h00000, 17'h1FFFF, 17'h0A5A5,
                                          17'h10001, 17'h0FF00, 17'h12345};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_pgm_n;
    logic [7:0]  rsp_data, mem_dq;
    logic [16:0] mem_addr;
    int          total = 0, bad = 0, lowcnt = 0;

    always #5 clk = ~clk;

    rom_rd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_pgm_n(mem_pgm_n), .mem_dq(mem_dq)
    );

    function automatic logic [7:0] pat(input logic [16:0] a);
        return a[7:0] ^ {a[16], a[14:8]} ^ 8'h3C;
    endfunction

    // memory model: poison byte until strobes have been low for the full window
    always @(posedge clk) lowcnt <= mem_ce_n ? 0 : lowcnt + 1;
    assign mem_dq = (!mem_ce_n && !mem_oe_n && lowcnt >= EXP_N - 1) ? pat(mem_addr) : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [16:0] a, input bit poke,
                           input bit hold_next, input logic [16:0] next_a);
        int lat = 0, flt = 0;
        bit stable = 1'b1, pgm_ok = 1'b1, high_ok = 1'b1;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && !mem_oe_n && !req_ready && mem_addr == a, "R4", int'(mem_addr), int'(a));
        while (!mem_ce_n) begin
            lat++;
            if (mem_addr != a) stable = 1'b0;
            if (mem_pgm_n !== 1'b1) pgm_ok = 1'b0;
            if (poke && lat == 3) begin req_valid = 1'b1; req_addr = 17'h1FFFF; end
            if (poke && lat == 4) begin req_valid = 1'b0; req_addr = a; end
            @(negedge clk);
        end
        chk(lat == EXP_N, "R5", lat, EXP_N);
        chk(stable, "R7", 0, 1);
        chk(pgm_ok, "R3", 0, 1);
        chk(rsp_valid == 1'b1 && rsp_data == pat(a), "R6", int'(rsp_data), int'(pat(a)));
        if (hold_next) begin req_valid = 1'b1; req_addr = next_a; end
        while (!req_ready) begin
            flt++;
            if (!mem_ce_n || !mem_oe_n) high_ok = 1'b0;
            if (flt == 2) chk(!rsp_valid, "R6", int'(rsp_valid), 0);
            @(negedge clk);
        end
        chk(flt == EXP_F && high_ok, "R8", flt, EXP_F);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1", int'({mem_ce_n, mem_oe_n, rsp_valid, req_ready}), 4'hD);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1", int'({mem_ce_n, mem_oe_n, rsp_valid, req_ready}), 4'hD);
        chk(mem_pgm_n === 1'b1, "R3", int'(mem_pgm_n), 1);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            do_read(VEC[i], 1'b0, 1'b0, '0);
            chk(mem_ce_n && mem_oe_n, "R2", int'({mem_ce_n, mem_oe_n}), 3);
        end

        // R9: request pulse while busy is ignored
        do_read(17'h00777, 1'b1, 1'b0, '0);
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (!mem_ce_n || rsp_valid || !req_ready) quiet = 1'b0;
            end
            chk(quiet && mem_addr == 17'h00777, "R9", int'(mem_addr), 17'h00777);
        end

        // back-to-back: request waiting as float recovery expires
        do_read(17'h0BEEF, 1'b0, 1'b1, 17'h04321);
        do_read(17'h04321, 1'b0, 1'b0, '0);
        chk(mem_ce_n && mem_oe_n && req_ready, "R2", int'({mem_ce_n, mem_oe_n}), 3);

        finish_run();
    end

endmodule